// File: doc/BRIEF.md
# Systolic Operand Scheduler with Byte-Serial Result Return

This block sits between a small matrix store and a 2x2 grid of multiply-accumulate cells. A free-running 3-bit cycle count drives it. From that count alone it decides which stored byte of the left matrix A and which stored byte of the right matrix B go onto the two row-entry ports and the two column-entry ports of the grid. Row 1 and column 1 are skewed one cycle behind row 0 and column 0, so matching terms meet in each cell. Cycles with nothing scheduled put zero on the ports. A transpose input makes the grid compute A·Bᵀ instead of A·B. Only the column-port selection changes, and the timing stays the same.

Once the grid has finished accumulating, the block raises the grid clear and captures all four 16-bit results into its own register in the same cycle. It then returns the results over one 8-bit host port, one byte per cycle. The order is C00, C01, C10, C11, with the high byte of each result before its low byte, and the low byte waits in a held tail register. While those bytes are leaving, the grid is already free for the next round. With the enable held high and the count wrapping, rounds stream back to back and the host port never goes idle.

Top module: `sysfeed_serializer`

## Requirements
- R1: Element A[r][c] sits at bits [(r*2+c)*8 +: 8] of `a_mat`. While `en` is high, row port i (`row_ops[i*8 +: 8]`) carries A[i][k] in the cycle where `cyc` equals i+k, for k = 0 and 1. In every other cycle it carries zero, so row 1 is idle at `cyc` 0.
- R2: Element B[r][c] sits at bits [(r*2+c)*8 +: 8] of `b_mat`. With `transpose` low and `en` high, column port j (`col_ops[j*8 +: 8]`) carries B[k][j] in the cycle where `cyc` equals j+k. In every other cycle it carries zero.
- R3: With `transpose` high, column port j carries B[j][k] in the cycle where `cyc` equals j+k. The cycles used are the same as with `transpose` low.
- R4: While `en` is low, all four operand ports are zero whatever `cyc` holds.
- R5: `array_clear` is high exactly in the cycles where `en` is high and `cyc` equals 4.
- R6: `results` holds C[i][j] at bits [(i*2+j)*16 +: 16]. It is sampled at the clock edge that ends a cycle with `array_clear` high. Over the next 8 cycles `host_byte` shows, in order: C00 high byte, C00 low byte, C01 high, C01 low, C10 high, C10 low, C11 high, C11 low.
- R7: `done` is high in exactly the cycles where `host_byte` carries a result byte. With `en` held high and `cyc` wrapping, `done` stays high across consecutive rounds.
- R8: Dropping `en` after a capture does not stop the serialisation. The remaining bytes still come out on the following cycles.
- R9: `host_byte` is zero whenever `done` is low.
- R10: After a synchronous reset (`rst` high), `done` is low and `host_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables operand feeding and result capture |
| cyc | input | 3 | Cycle count, wrapping 0 to 7 while enabled |
| transpose | input | 1 | Selects A·Bᵀ instead of A·B |
| a_mat | input | 32 | Stored left matrix, row-major |
| b_mat | input | 32 | Stored right matrix, row-major |
| results | input | 64 | Accumulated results from the grid |
| row_ops | output | 16 | Row-entry operands, lane i at [i*8 +: 8] |
| col_ops | output | 16 | Column-entry operands, lane j at [j*8 +: 8] |
| host_byte | output | 8 | Serialised result byte |
| done | output | 1 | `host_byte` carries a valid byte |
| array_clear | output | 1 | Clears the grid accumulators |

## Verification
The operand ports and `array_clear` are combinational from `cyc`, so they are checked in the same cycle the count is applied. The bench samples them at the falling edge, after driving inputs just past the previous falling edge. The first byte, C00 high, is due in the cycle right after the capture edge, and each later byte is due exactly one cycle after the byte before it. The bench therefore builds an eight-entry byte queue at the capture edge and pops one entry per rising edge, with no extra slack. Its behavioural model of the grid accumulates the actual port values with delays of one cycle per hop. This makes the captured results depend on the skew being correct, and each byte is compared with the matrix product computed directly.

// File: rtl/sysfeed_pkg.sv
package sysfeed_pkg;
   // Default geometry of the scheduler.
   localparam int SF_DIM    = 2;
   localparam int SF_DATA_W = 8;
   localparam int SF_CYC_W  = 3;

   // Cycle in which the last cell of a DIM x DIM grid holds its final sum:
   // the last operands enter at cycle 2*(DIM-1) and need DIM-1 more hops.
   function automatic int capt_cycle(input int dim);
      return 3 * dim - 2;
   endfunction
endpackage

// File: rtl/sysfeed_operand_sel.sv
module sysfeed_operand_sel #(
   parameter int DIM    = 2,
   parameter int DATA_W = 8,
   parameter int CYC_W  = 3
) (
   input  logic                      en,
   input  logic [CYC_W-1:0]          cyc,
   input  logic                      transpose,
   input  logic [DIM*DIM*DATA_W-1:0] a_mat,
   input  logic [DIM*DIM*DATA_W-1:0] b_mat,
   output logic [DIM*DATA_W-1:0]     row_ops,
   output logic [DIM*DATA_W-1:0]     col_ops
);
   // Lane i takes its k-th term in cycle i+k; anything else drives zero.
   always_comb begin
      row_ops = '0;
      if (en) begin
         for (int i = 0; i < DIM; i++) begin
            for (int k = 0; k < DIM; k++) begin
               if (cyc == CYC_W'(i + k))
                  row_ops[i*DATA_W +: DATA_W] = a_mat[(i*DIM + k)*DATA_W +: DATA_W];
            end
         end
      end
   end

   // Column lane j: plain product walks B down column j, transposed
   // product walks B along row j; the schedule is identical.
   always_comb begin
      col_ops = '0;
      if (en) begin
         for (int j = 0; j < DIM; j++) begin
            for (int k = 0; k < DIM; k++) begin
               if (cyc == CYC_W'(j + k)) begin
                  if (transpose)
                     col_ops[j*DATA_W +: DATA_W] = b_mat[(j*DIM + k)*DATA_W +: DATA_W];
                  else
                     col_ops[j*DATA_W +: DATA_W] = b_mat[(k*DIM + j)*DATA_W +: DATA_W];
               end
            end
         end
      end
   end
endmodule

// File: rtl/sysfeed_byte_ser.sv
module sysfeed_byte_ser #(
   parameter int DATA_W = 8,
   parameter int NRES   = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       capture,
   input  logic [NRES*2*DATA_W-1:0]   res_flat,
   output logic [DATA_W-1:0]          host_byte,
   output logic                       done
);
   localparam int RES_W  = 2 * DATA_W;
   localparam int NBYTES = 2 * NRES;
   localparam int CNT_W  = $clog2(NBYTES);

   logic [RES_W-1:0]  res_q [NRES];
   logic [DATA_W-1:0] tail_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  idx;

   // Byte index being emitted next: NBYTES - rem, modulo a power of two.
   assign idx = CNT_W'(0) - rem_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q     <= '0;
         done      <= 1'b0;
         host_byte <= '0;
         tail_q    <= '0;
         for (int n = 0; n < NRES; n++) res_q[n] <= '0;
      end else if (capture) begin
         for (int n = 0; n < NRES; n++) res_q[n] <= res_flat[n*RES_W +: RES_W];
         host_byte <= res_flat[RES_W-1:DATA_W];
         tail_q    <= res_flat[DATA_W-1:0];
         rem_q     <= CNT_W'(NBYTES - 1);
         done      <= 1'b1;
      end else if (rem_q != '0) begin
         rem_q <= rem_q - 1'b1;
         done  <= 1'b1;
         if (idx[0]) begin
            host_byte <= tail_q;
         end else begin
            host_byte <= res_q[idx[CNT_W-1:1]][RES_W-1:DATA_W];
            tail_q    <= res_q[idx[CNT_W-1:1]][DATA_W-1:0];
         end
      end else begin
         done      <= 1'b0;
         host_byte <= '0;
      end
   end
endmodule

// File: rtl/sysfeed_serializer.sv
module sysfeed_serializer
   import sysfeed_pkg::*;
#(
   parameter int DIM      = SF_DIM,
   parameter int DATA_W   = SF_DATA_W,
   parameter int CYC_W    = SF_CYC_W,
   parameter int CAPT_CYC = capt_cycle(SF_DIM)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          en,
   input  logic [CYC_W-1:0]              cyc,
   input  logic                          transpose,
   input  logic [DIM*DIM*DATA_W-1:0]     a_mat,
   input  logic [DIM*DIM*DATA_W-1:0]     b_mat,
   input  logic [DIM*DIM*2*DATA_W-1:0]   results,
   output logic [DIM*DATA_W-1:0]         row_ops,
   output logic [DIM*DATA_W-1:0]         col_ops,
   output logic [DATA_W-1:0]             host_byte,
   output logic                          done,
   output logic                          array_clear
);
   localparam int NRES   = DIM * DIM;
   localparam int NBYTES = 2 * NRES;

   // Elaboration-time consistency of the parameter set.
   if (NBYTES != (1 << CYC_W)) begin : g_bad_period
      $error("byte count %0d must equal cycle period %0d", NBYTES, 1 << CYC_W);
   end
   if (CAPT_CYC < capt_cycle(DIM) || CAPT_CYC >= (1 << CYC_W)) begin : g_bad_capt
      $error("capture cycle %0d outside the legal window", CAPT_CYC);
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("operand width must be positive");
   end

   logic capture;
   assign capture     = en && (cyc == CYC_W'(CAPT_CYC));
   assign array_clear = capture;

   sysfeed_operand_sel #(
      .DIM    (DIM),
      .DATA_W (DATA_W),
      .CYC_W  (CYC_W)
   ) u_sel (
      .en        (en),
      .cyc       (cyc),
      .transpose (transpose),
      .a_mat     (a_mat),
      .b_mat     (b_mat),
      .row_ops   (row_ops),
      .col_ops   (col_ops)
   );

   sysfeed_byte_ser #(
      .DATA_W (DATA_W),
      .NRES   (NRES)
   ) u_ser (
      .clk       (clk),
      .rst       (rst),
      .capture   (capture),
      .res_flat  (results),
      .host_byte (host_byte),
      .done      (done)
   );
endmodule

// File: rtl/sysfeed_checker.sv
module sysfeed_checker #(
   parameter int DIM    = 2,
   parameter int DATA_W = 8,
   parameter int CYC_W  = 3
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        en,
   input logic [CYC_W-1:0]            cyc,
   input logic [DIM*DIM*2*DATA_W-1:0] results,
   input logic [DIM*DATA_W-1:0]       row_ops,
   input logic [DIM*DATA_W-1:0]       col_ops,
   input logic [DATA_W-1:0]           host_byte,
   input logic                        done,
   input logic                        array_clear
);
   localparam int RES_W = 2 * DATA_W;

   AST_IDLE_OPS_ZERO: assert property (@(posedge clk) disable iff (rst)
      !en |-> (row_ops == '0 && col_ops == '0));                                  // R4
   AST_LATE_LANES_IDLE: assert property (@(posedge clk) disable iff (rst)
      (en && cyc == '0) |-> (row_ops[DIM*DATA_W-1:DATA_W] == '0
                            && col_ops[DIM*DATA_W-1:DATA_W] == '0));             // R1
   AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
      array_clear |=> (done && host_byte == $past(results[RES_W-1:DATA_W])));     // R6
   AST_TAIL_BYTE: assert property (@(posedge clk) disable iff (rst)
      array_clear |=> ##1 (done && host_byte == $past(results[DATA_W-1:0], 2)));  // R6
   AST_QUIET_PORT: assert property (@(posedge clk) disable iff (rst)
      !done |-> host_byte == '0);                                                 // R9
endmodule

bind sysfeed_serializer sysfeed_checker #(
   .DIM    (DIM),
   .DATA_W (DATA_W),
   .CYC_W  (CYC_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .en          (en),
   .cyc         (cyc),
   .results     (results),
   .row_ops     (row_ops),
   .col_ops     (col_ops),
   .host_byte   (host_byte),
   .done        (done),
   .array_clear (array_clear)
);

// File: tb/sysfeed_serializer_test.sv
module sysfeed_serializer_test;
   localparam int CLK_NS = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        en;
   logic [2:0]  cyc;
   logic        transpose;
   logic [31:0] a_mat, b_mat;
   logic [63:0] results;
   logic [15:0] row_ops, col_ops;
   logic [7:0]  host_byte;
   logic        done, array_clear;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   int ma[4];
   int mb[4];

   // behavioural grid model
   logic signed [15:0] acc[4];
   int ap[2];
   int bp[2];
   int exp_q[$];
   int cur_b;
   bit cur_v;

   always #(CLK_NS/2) clk = ~clk;

   sysfeed_serializer uut (
      .clk(clk), .rst(rst), .en(en), .cyc(cyc), .transpose(transpose),
      .a_mat(a_mat), .b_mat(b_mat), .results(results),
      .row_ops(row_ops), .col_ops(col_ops), .host_byte(host_byte),
      .done(done), .array_clear(array_clear)
   );

   always_comb begin
      for (int n = 0; n < 4; n++) results[n*16 +: 16] = acc[n];
      for (int n = 0; n < 4; n++) begin
         a_mat[n*8 +: 8] = 8'(ma[n]);
         b_mat[n*8 +: 8] = 8'(mb[n]);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_round(input int r);
      case (r)
         0: begin ma = '{1, 2, 3, 4};         mb = '{5, 6, 7, 8};          transpose = 0; end
         1: begin ma = '{-3, 7, 12, -9};      mb = '{4, -2, 11, 6};        transpose = 1; end
         2: begin ma = '{-128, -128, -128, -128}; mb = '{-128, -128, -128, -128}; transpose = 0; end
         default: begin ma = '{127, -128, 5, 0}; mb = '{-1, 127, -128, 3}; transpose = 1; end
      endcase
   endtask

   // Model: grid cell (i,j) sees row lane i delayed j cycles and column
   // lane j delayed i cycles; the expected byte stream is the true product.
   always @(posedge clk) begin
      if (rst) begin
         for (int n = 0; n < 4; n++) acc[n] <= '0;
         ap = '{0, 0}; bp = '{0, 0};
         exp_q.delete(); cur_b = 0; cur_v = 0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 2; j++) begin
               int av, bv;
               av = (j == 0) ? int'($signed(row_ops[i*8 +: 8])) : ap[i];
               bv = (i == 0) ? int'($signed(col_ops[j*8 +: 8])) : bp[j];
               acc[i*2+j] <= array_clear ? 16'sd0 : 16'(int'(acc[i*2+j]) + av * bv);
            end
         end
         for (int i = 0; i < 2; i++) begin
            ap[i] = int'($signed(row_ops[i*8 +: 8]));
            bp[i] = int'($signed(col_ops[i*8 +: 8]));
         end
         if (en && cyc == 3'd4) begin
            exp_q.delete();
            for (int i = 0; i < 2; i++) begin
               for (int j = 0; j < 2; j++) begin
                  int s;
                  s = 0;
                  for (int k = 0; k < 2; k++)
                     s += ma[i*2+k] * (transpose ? mb[j*2+k] : mb[k*2+j]);
                  exp_q.push_back((s >> 8) & 8'hFF);
                  exp_q.push_back(s & 8'hFF);
               end
            end
            cur_b = exp_q.pop_front(); cur_v = 1;
         end else if (exp_q.size() > 0) begin
            cur_b = exp_q.pop_front(); cur_v = 1;
         end else begin
            cur_b = 0; cur_v = 0;
         end
      end
   end

   // Comparison every cycle, away from the rising edge.
   always @(negedge clk) begin
      if (!rst && !finished) begin
         int ea[2];
         int eb[2];
         ea = '{0, 0}; eb = '{0, 0};
         if (en) begin
            case (cyc)
               3'd0: begin ea[0] = ma[0]; eb[0] = mb[0]; end
               3'd1: begin
                  ea[0] = ma[1]; ea[1] = ma[2];
                  eb[0] = transpose ? mb[1] : mb[2];
                  eb[1] = transpose ? mb[2] : mb[1];
               end
               3'd2: begin ea[1] = ma[3]; eb[1] = mb[3]; end
               default: ;
            endcase
         end
         for (int i = 0; i < 2; i++) begin
            chk(!en ? "R4 row" : "R1 row", int'(row_ops[i*8 +: 8]), ea[i] & 8'hFF);
            chk(!en ? "R4 col" : (transpose ? "R3 col" : "R2 col"),
                int'(col_ops[i*8 +: 8]), eb[i] & 8'hFF);
         end
         chk("R5 clear", int'(array_clear), int'(en && cyc == 3'd4));
         chk(!cur_v ? "R9 idle byte" : (!en ? "R8 byte" : "R6 byte"),
             int'(host_byte), cur_b);
         chk("R7 done", int'(done), int'(cur_v));
      end
   end

   initial begin
      rst = 1; en = 0; cyc = '0;
      load_round(0);
      repeat (3) @(negedge clk);
      chk("R10 done", int'(done), 0);
      chk("R10 byte", int'(host_byte), 0);
      #1;
      rst = 0; en = 1; cyc = '0;
      begin
         int rnd;
         rnd = 0;
         while (en) begin
            @(negedge clk); #1;
            cyc = cyc + 3'd1;
            if (cyc == 3'd5) begin
               rnd++;
               if (rnd < 4) load_round(rnd);
               else en = 0;
            end
         end
      end
      repeat (10) @(negedge clk);
      #1 cyc = 3'd1; transpose = 0;
      repeat (3) @(negedge clk);
      #1 cyc = 3'd2;
      repeat (3) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_NS * 20000);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule